// File: doc/BRIEF.md
# Descriptor Chain Channel Engine

This block is a single channel of a descriptor-driven copy coprocessor. Software writes the address of a first descriptor into the command pointer and then adds a count to the channel semaphore. While that count is non-zero the engine reads descriptors from memory over a request/response port. For each descriptor it copies the block of bytes from the source address to the destination address one 32-bit word at a time, then writes a completion word back into the descriptor.

A descriptor is eight 32-bit words: the next pointer at +0, control word 0 at +4, control word 1 at +8, the source address at +12, the destination address at +16, the byte count at +20, the payload pointer at +24 and the status word at +28. Control word 0 carries the per-descriptor options: interrupt, semaphore decrement, chain, and the cipher selections. Descriptors can be linked into chains or into a closed ring. Each copied word passes through a hook where a cipher would sit; with the default mask that hook leaves the data unchanged. Errors stop the channel and are reported in a status register together with an interrupt strobe.

The memory port has one request channel with valid/ready handshaking. A request whose valid is high and whose ready is low keeps its address, write flag and write data unchanged until ready is seen. Only one request is outstanding at a time, and every accepted request, read or write, is answered by exactly one response cycle on `mem_rsp_valid`. The response channel has no ready, so the engine always accepts it.

Top module: `desc_chan_engine`

## Requirements
- R1: The engine reads descriptor words +0 (next), +4 (control 0), +12 (source), +16 (destination) and +20 (byte count) from the current pointer. It then copies the byte count from source to destination as ascending 32-bit words. When control 0 bit 5 is set and only one key source is selected, the copied data is unchanged.
- R2: A semaphore write adds its value to the pending count. From idle, the engine starts only after a semaphore write, and only while the count is non-zero. With a zero count it issues no memory request.
- R3: After a descriptor completes, the count is decremented by one if control 0 bit 1 is set. Otherwise the count is left as it is.
- R4: A completed descriptor gets the value 1 written into its status word at +28. A zero byte count performs only this write.
- R5: Control 0 bit 0 produces a one-cycle `irq` pulse when the descriptor completes. Without it, a clean completion gives no pulse.
- R6: With control 0 bit 2 set, the engine continues at the next pointer whenever the count is non-zero, so a closed ring keeps running. When the count is zero it waits with `waiting` high.
- R7: A chained descriptor whose next pointer is zero sets error code 1 in status bits 23:16 after it completes, and then halts.
- R8: A byte count that is not a multiple of 16 sets flag 0x04. No data is moved and no status word is written.
- R9: An error response sets a flag in the status register: 0x08 for a descriptor fetch or status write-back, 0x10 for a source read, 0x20 for a destination write. Every error, including those in R7, R8 and R10, halts the channel (`running` low) and pulses `irq` whatever control 0 bit 0 says.
- R10: Control 0 bit 5 with both key-source bits 10 and 11 set is an invalid mode. It sets error code 5 and no data is moved.
- R11: A command pointer write clears the status register on the next cycle. If the engine is halted or waiting, the write also returns it to idle. After a descriptor without the chain bit the engine goes idle, and its next start reads the command pointer again.
- R12: A request is held stable while it is not accepted, and every write the engine issues targets an expected location with the expected data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_ptr_wr | input | 1 | Command pointer write strobe |
| cmd_ptr_wdata | input | AW | Address of the first descriptor |
| sema_wr | input | 1 | Semaphore write strobe |
| sema_wdata | input | SW | Count to add to the semaphore |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | AW | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_rdata | input | 32 | Read data |
| mem_rsp_err | input | 1 | Error response |
| sema_count | output | SW | Pending semaphore count |
| chan_status | output | 32 | Error code in bits 23:16, error flags in bits 7:0 |
| running | output | 1 | High unless idle or halted |
| waiting | output | 1 | Chained and waiting for a non-zero count |
| irq | output | 1 | One-cycle completion or error strobe |

## Verification
The semaphore count and the status clear are registered, so they become visible one cycle after their write strobe. The bench reads them at the falling edge that follows. An error flag or code and its `irq` pulse appear together, one cycle after the faulty response or the check cycle, and the bench counts `irq` pulses at every falling edge rather than waiting for a fixed cycle. The length of a descriptor run depends on how often the memory model raises ready, so the bench waits for the engine to settle in idle, halt or wait for several cycles before it compares status, count and memory. Each write the engine issues is checked on the cycle it is accepted, against the memory image the bench has computed.

// File: rtl/chn_pkg.sv
package chn_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT, ST_FREQ, ST_FRSP, ST_CHECK,
    ST_RREQ, ST_RRSP, ST_WREQ, ST_WRSP,
    ST_SREQ, ST_SRSP, ST_DONE, ST_HALT
  } chn_state_e;

  // descriptor word offsets (word index)
  localparam logic [2:0] W_NEXT = 3'd0;
  localparam logic [2:0] W_CTL0 = 3'd1;
  localparam logic [2:0] W_SRC  = 3'd3;
  localparam logic [2:0] W_DST  = 3'd4;
  localparam logic [2:0] W_LEN  = 3'd5;
  localparam logic [2:0] W_STAT = 3'd7;

  // control word 0 bit positions
  localparam int CB_IRQ   = 0;
  localparam int CB_DEC   = 1;
  localparam int CB_CHAIN = 2;
  localparam int CB_CIPH  = 5;
  localparam int CB_HWKEY = 10;
  localparam int CB_PLKEY = 11;

  // status codes and flags
  localparam logic [7:0] CODE_NEXT_ZERO = 8'd1;
  localparam logic [7:0] CODE_BAD_MODE  = 8'd5;
  localparam logic [7:0] FLG_DST   = 8'h20;
  localparam logic [7:0] FLG_SRC   = 8'h10;
  localparam logic [7:0] FLG_FETCH = 8'h08;
  localparam logic [7:0] FLG_SETUP = 8'h04;

  typedef struct packed {
    logic pl_key;
    logic hw_key;
    logic ciph;
    logic chain;
    logic dec;
    logic irq;
  } ctl_t;

endpackage

// File: rtl/chn_sema.sv
module chn_sema #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_en,
  input  logic [SW-1:0] add_val,
  input  logic          dec_en,
  output logic [SW-1:0] count
);
  logic [SW:0] sum_add;
  logic [SW:0] sum_net;

  always_comb begin
    sum_add = {1'b0, count} + (add_en ? {1'b0, add_val} : '0);
    sum_net = sum_add;
    if (dec_en && (sum_add != '0)) sum_net = sum_add - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (sum_net[SW])  count <= '1;
    else                   count <= sum_net[SW-1:0];
  end
endmodule

// File: rtl/chn_status.sv
module chn_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        code_en,
  input  logic [7:0]  code,
  input  logic        flag_en,
  input  logic [7:0]  flags,
  output logic [31:0] status
);
  logic [7:0] code_q;
  logic [7:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      flags_q <= '0;
    end else if (clr) begin
      code_q  <= '0;
      flags_q <= '0;
    end else begin
      if (code_en && code_q == '0) code_q <= code;
      if (flag_en) flags_q <= flags_q | flags;
    end
  end

  assign status = {8'h00, code_q, 8'h00, flags_q};
endmodule

// File: rtl/chn_hook.sv
module chn_hook #(
  parameter int          DW   = 32,
  parameter logic [31:0] MASK = '0
) (
  input  logic          enable,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  // cipher insertion point; the mask stands in for a keyed transform
  assign dout = din ^ (enable ? DW'(MASK) : '0);
endmodule

// File: rtl/desc_chan_engine.sv
module desc_chan_engine
  import chn_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          SW        = 8,
  parameter logic [31:0] HOOK_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_ptr_wr,
  input  logic [AW-1:0] cmd_ptr_wdata,
  input  logic          sema_wr,
  input  logic [SW-1:0] sema_wdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_rdata,
  input  logic          mem_rsp_err,
  output logic [SW-1:0] sema_count,
  output logic [31:0]   chan_status,
  output logic          running,
  output logic          waiting,
  output logic          irq
);
  localparam int DW = 32;

  chn_state_e    st_q;
  logic [AW-1:0] cmd_ptr_q, cur_q, next_q, src_q, dst_q, off_q;
  logic [DW-1:0] len_q, data_q, hook_out;
  logic [2:0]    fidx_q;
  ctl_t          ctl_q;
  logic          kick_q, irq_q;
  logic          sema_dec;
  logic          code_en, flag_en, fail, rsp_ok, rsp_bad;
  logic [7:0]    code_val, flag_val;
  logic          idle_like;

  assign rsp_ok    = mem_rsp_valid && !mem_rsp_err;
  assign rsp_bad   = mem_rsp_valid &&  mem_rsp_err;
  assign sema_dec  = (st_q == ST_DONE) && ctl_q.dec;
  assign idle_like = (st_q == ST_IDLE) || (st_q == ST_WAIT) || (st_q == ST_HALT);

  chn_sema #(.SW(SW)) u_sema (
    .clk(clk), .rst_n(rst_n),
    .add_en(sema_wr), .add_val(sema_wdata),
    .dec_en(sema_dec), .count(sema_count)
  );

  chn_status u_status (
    .clk(clk), .rst_n(rst_n), .clr(cmd_ptr_wr),
    .code_en(code_en), .code(code_val),
    .flag_en(flag_en), .flags(flag_val),
    .status(chan_status)
  );

  chn_hook #(.DW(DW), .MASK(HOOK_MASK)) u_hook (
    .enable(ctl_q.ciph), .din(mem_rsp_rdata), .dout(hook_out)
  );

  // error detection
  always_comb begin
    code_en  = 1'b0;
    code_val = '0;
    flag_en  = 1'b0;
    flag_val = '0;
    case (st_q)
      ST_FRSP, ST_SRSP: if (rsp_bad) begin flag_en = 1'b1; flag_val = FLG_FETCH; end
      ST_RRSP:          if (rsp_bad) begin flag_en = 1'b1; flag_val = FLG_SRC;   end
      ST_WRSP:          if (rsp_bad) begin flag_en = 1'b1; flag_val = FLG_DST;   end
      ST_CHECK: begin
        if (ctl_q.ciph && ctl_q.hw_key && ctl_q.pl_key) begin
          code_en  = 1'b1;
          code_val = CODE_BAD_MODE;
        end else if (len_q[3:0] != 4'h0) begin
          flag_en  = 1'b1;
          flag_val = FLG_SETUP;
        end
      end
      ST_DONE: if (ctl_q.chain && next_q == '0) begin
        code_en  = 1'b1;
        code_val = CODE_NEXT_ZERO;
      end
      default: ;
    endcase
  end
  assign fail = code_en || flag_en;

  // memory request mux
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    case (st_q)
      ST_FREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = cur_q + AW'({fidx_q, 2'b00});
      end
      ST_RREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = src_q + off_q;
      end
      ST_WREQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = dst_q + off_q;
        mem_req_wdata = data_q;
      end
      ST_SREQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = cur_q + AW'({W_STAT, 2'b00});
        mem_req_wdata = 32'd1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cmd_ptr_q <= '0;
      cur_q     <= '0;
      next_q    <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      off_q     <= '0;
      len_q     <= '0;
      data_q    <= '0;
      fidx_q    <= '0;
      ctl_q     <= '0;
      kick_q    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= fail || ((st_q == ST_DONE) && ctl_q.irq);
      if (cmd_ptr_wr) cmd_ptr_q <= cmd_ptr_wdata;

      case (st_q)
        ST_IDLE: if (kick_q && sema_count != '0) begin
          cur_q  <= cmd_ptr_q;
          fidx_q <= '0;
          kick_q <= 1'b0;
          st_q   <= ST_FREQ;
        end
        ST_WAIT: if (sema_count != '0) begin
          fidx_q <= '0;
          st_q   <= ST_FREQ;
        end
        ST_FREQ: if (mem_req_ready) st_q <= ST_FRSP;
        ST_FRSP: if (rsp_ok) begin
          case (fidx_q)
            W_NEXT: next_q <= AW'(mem_rsp_rdata);
            W_CTL0: ctl_q  <= '{pl_key: mem_rsp_rdata[CB_PLKEY],
                                hw_key: mem_rsp_rdata[CB_HWKEY],
                                ciph:   mem_rsp_rdata[CB_CIPH],
                                chain:  mem_rsp_rdata[CB_CHAIN],
                                dec:    mem_rsp_rdata[CB_DEC],
                                irq:    mem_rsp_rdata[CB_IRQ]};
            W_SRC:  src_q  <= AW'(mem_rsp_rdata);
            W_DST:  dst_q  <= AW'(mem_rsp_rdata);
            W_LEN:  len_q  <= mem_rsp_rdata;
            default: ;
          endcase
          if (fidx_q == W_LEN) st_q <= ST_CHECK;
          else begin
            fidx_q <= fidx_q + 3'd1;
            st_q   <= ST_FREQ;
          end
        end
        ST_CHECK: begin
          off_q <= '0;
          st_q  <= (len_q[DW-1:4] == '0) ? ST_SREQ : ST_RREQ;
        end
        ST_RREQ: if (mem_req_ready) st_q <= ST_RRSP;
        ST_RRSP: if (rsp_ok) begin
          data_q <= hook_out;
          st_q   <= ST_WREQ;
        end
        ST_WREQ: if (mem_req_ready) st_q <= ST_WRSP;
        ST_WRSP: if (rsp_ok) begin
          off_q <= off_q + AW'(4);
          st_q  <= (off_q + AW'(4) == AW'(len_q)) ? ST_SREQ : ST_RREQ;
        end
        ST_SREQ: if (mem_req_ready) st_q <= ST_SRSP;
        ST_SRSP: if (rsp_ok) st_q <= ST_DONE;
        ST_DONE: begin
          if (ctl_q.chain) begin
            cur_q <= next_q;
            st_q  <= ST_WAIT;
          end else begin
            st_q  <= ST_IDLE;
          end
        end
        default: ;
      endcase

      if (fail)    st_q   <= ST_HALT;
      if (sema_wr) kick_q <= 1'b1;
      if (cmd_ptr_wr && idle_like) begin
        st_q   <= ST_IDLE;
        kick_q <= 1'b0;
      end
    end
  end

  assign running = (st_q != ST_IDLE) && (st_q != ST_HALT);
  assign waiting = (st_q == ST_WAIT);
  assign irq     = irq_q;
endmodule

// File: rtl/chn_checker.sv
module chn_checker #(
  parameter int AW = 32,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ptr_wr,
  input logic          sema_wr,
  input logic [SW-1:0] sema_wdata,
  input logic          sema_dec,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [31:0]   mem_req_wdata,
  input logic [SW-1:0] sema_count,
  input logic [31:0]   chan_status,
  input logic          running
);
  logic [SW:0] add_sum;
  assign add_sum = {1'b0, sema_count} + {1'b0, sema_wdata};

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata));

  assert_quiet_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !mem_req_valid);

  assert_sema_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sema_wr && !sema_dec && !add_sum[SW] |=> sema_count == $past(add_sum[SW-1:0]));

  assert_sema_dec_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sema_dec && !sema_wr |-> sema_count != '0);

  assert_status_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ptr_wr |=> chan_status == 32'h0);

  assert_code_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_status[23:16] <= 8'd5);
endmodule

bind desc_chan_engine chn_checker #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ptr_wr(cmd_ptr_wr),
  .sema_wr(sema_wr), .sema_wdata(sema_wdata), .sema_dec(sema_dec),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .sema_count(sema_count),
  .chan_status(chan_status), .running(running)
);

// File: tb/test_desc_chan_engine.sv
module test_desc_chan_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_ptr_wr = 1'b0;
  logic [31:0] cmd_ptr_wdata = '0;
  logic        sema_wr = 1'b0;
  logic [7:0]  sema_wdata = '0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        mem_rsp_err = 1'b0;
  logic [7:0]  sema_count;
  logic [31:0] chan_status;
  logic        running, waiting, irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int exp_irq = 0;

  logic [31:0] mem  [0:1023];
  logic [31:0] refm [0:1023];
  bit          wr_ok[0:1023];
  logic [7:0]  lfsr = 8'h5A;

  always #2.5 clk = ~clk;

  desc_chan_engine i_desc_chan_engine (
    .clk(clk), .rst_n(rst_n),
    .cmd_ptr_wr(cmd_ptr_wr), .cmd_ptr_wdata(cmd_ptr_wdata),
    .sema_wr(sema_wr), .sema_wdata(sema_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .mem_rsp_err(mem_rsp_err),
    .sema_count(sema_count), .chan_status(chan_status),
    .running(running), .waiting(waiting), .irq(irq)
  );

  function automatic int wi(input logic [31:0] a);
    return int'(a[11:2]);
  endfunction

  // memory model: one response the cycle after acceptance, error above 2 GB
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_req_ready <= 1'b0;
    end else begin
      lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready <= lfsr[0] | lfsr[2];
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_err   <= mem_req_addr[31];
        mem_rsp_rdata <= mem_req_addr[31] ? 32'h0 : mem[wi(mem_req_addr)];
        if (mem_req_write && !mem_req_addr[31]) mem[wi(mem_req_addr)] <= mem_req_wdata;
      end
    end
  end

  // per-cycle reference comparison of every accepted write, and irq counting
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (mem_req_valid && mem_req_ready && mem_req_write) begin
        checks++;
        if (!mem_req_addr[31] &&
            !(wr_ok[wi(mem_req_addr)] && mem_req_wdata == refm[wi(mem_req_addr)])) begin
          errors++;
          $display("FAIL R12 write addr %h data %h, expected data %h allowed %0d",
                   mem_req_addr, mem_req_wdata, refm[wi(mem_req_addr)], wr_ok[wi(mem_req_addr)]);
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    mem[wi(a)]  = d;
    refm[wi(a)] = d;
  endtask

  task automatic put_desc(input logic [31:0] base, nxt, ctl, src, dst, len);
    put(base,      nxt);
    put(base + 4,  ctl);
    put(base + 8,  32'h0);
    put(base + 12, src);
    put(base + 16, dst);
    put(base + 20, len);
    put(base + 24, 32'h0);
    put(base + 28, 32'h0);
  endtask

  task automatic fill_src(input logic [31:0] src, input int len, input logic [31:0] seed);
    for (int i = 0; i < len / 4; i++) put(src + 32'(4 * i), seed ^ (32'(i) * 32'h0102_0304));
  endtask

  task automatic exp_copy(input logic [31:0] src, dst, input int len);
    for (int i = 0; i < len / 4; i++) begin
      refm[wi(dst + 32'(4 * i))]  = mem[wi(src + 32'(4 * i))];
      wr_ok[wi(dst + 32'(4 * i))] = 1'b1;
    end
  endtask

  task automatic exp_done(input logic [31:0] base);
    refm[wi(base + 28)]  = 32'd1;
    wr_ok[wi(base + 28)] = 1'b1;
  endtask

  task automatic clr_ok();
    for (int i = 0; i < 1024; i++) wr_ok[i] = 1'b0;
  endtask

  task automatic cmp_mem(input string req);
    int bad = -1;
    for (int i = 0; i < 1024; i++) if (bad < 0 && mem[i] !== refm[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s memory word %h actual %h expected %h", req, bad * 4, mem[bad], refm[bad]);
    end
  endtask

  task automatic wr_cmd(input logic [31:0] a);
    @(negedge clk);
    cmd_ptr_wr = 1'b1; cmd_ptr_wdata = a;
    @(negedge clk);
    cmd_ptr_wr = 1'b0;
  endtask

  task automatic wr_sema(input logic [7:0] v);
    @(negedge clk);
    sema_wr = 1'b1; sema_wdata = v;
    @(negedge clk);
    sema_wr = 1'b0;
  endtask

  task automatic settle();
    int quiet = 0;
    repeat (4) @(negedge clk);
    for (int n = 0; n < 5000 && quiet < 6; n++) begin
      @(negedge clk);
      if ((!running || waiting) && !mem_req_valid && !mem_rsp_valid) quiet++;
      else quiet = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = '0; refm[i] = '0; wr_ok[i] = 1'b0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R2 R11: reset state
    check("R2 reset count", 32'(sema_count), 0);
    check("R11 reset status", chan_status, 0);
    check("R11 reset running", 32'(running), 0);
    check("R5 reset irq", 32'(irq), 0);
    check("R12 reset request", 32'(mem_req_valid), 0);
    rst_n = 1'b1;

    // R1 R3 R4 R5: single descriptor, 32 bytes, irq and decrement
    clr_ok();
    put_desc(32'h100, 0, 32'h3, 32'h400, 32'h800, 32);
    fill_src(32'h400, 32, 32'hA5A5_0000);
    exp_copy(32'h400, 32'h800, 32); exp_done(32'h100);
    wr_cmd(32'h100); wr_sema(8'd1); settle();
    exp_irq += 1;
    cmp_mem("R1 copy and R4 status word");
    check("R3 count decremented", 32'(sema_count), 0);
    check("R5 irq pulse", 32'(irq_cnt), 32'(exp_irq));
    check("R11 idle after unchained", 32'(running), 0);

    // R5: no irq bit, clean completion gives no pulse
    clr_ok();
    put_desc(32'h140, 0, 32'h2, 32'h420, 32'h820, 16);
    fill_src(32'h420, 16, 32'h1111_2222);
    exp_copy(32'h420, 32'h820, 16); exp_done(32'h140);
    wr_cmd(32'h140); wr_sema(8'd1); settle();
    cmp_mem("R4 second descriptor");
    check("R5 no irq without bit 0", 32'(irq_cnt), 32'(exp_irq));

    // R2: pointer loaded, no semaphore write, nothing happens
    clr_ok();
    put_desc(32'h180, 0, 32'h0, 32'h440, 32'h840, 16);
    fill_src(32'h440, 16, 32'h3333_0000);
    wr_cmd(32'h180);
    repeat (40) @(negedge clk);
    check("R2 gated status word", mem[wi(32'h19C)], 0);
    check("R2 gated running", 32'(running), 0);
    // R3: no decrement bit keeps the count
    exp_copy(32'h440, 32'h840, 16); exp_done(32'h180);
    wr_sema(8'd2); settle();
    cmp_mem("R1 copy after gate");
    check("R3 count kept without bit 1", 32'(sema_count), 2);
    // R11: next start rereads the command pointer
    put_desc(32'h1C0, 0, 32'h3, 32'h460, 32'h860, 16);
    fill_src(32'h460, 16, 32'h4444_0000);
    exp_copy(32'h460, 32'h860, 16); exp_done(32'h1C0);
    wr_cmd(32'h1C0); wr_sema(8'd3); settle();
    exp_irq += 1;
    cmp_mem("R11 new command pointer used");
    check("R2 count added then decremented", 32'(sema_count), 4);

    // R6: two-descriptor ring, count 5 -> five runs
    clr_ok();
    put_desc(32'h200, 32'h220, 32'h7, 32'h480, 32'h880, 16);
    put_desc(32'h220, 32'h200, 32'h7, 32'h4A0, 32'h8A0, 16);
    fill_src(32'h480, 16, 32'h5555_0000);
    fill_src(32'h4A0, 16, 32'h6666_0000);
    exp_copy(32'h480, 32'h880, 16); exp_done(32'h200);
    exp_copy(32'h4A0, 32'h8A0, 16); exp_done(32'h220);
    wr_cmd(32'h200); wr_sema(8'd1); settle();
    exp_irq += 5;
    cmp_mem("R6 ring copies");
    check("R6 ring ran five times", 32'(irq_cnt), 32'(exp_irq));
    check("R6 count drained", 32'(sema_count), 0);
    check("R6 waiting", 32'(waiting), 1);

    // R7: chained descriptor with zero next pointer
    clr_ok();
    put_desc(32'h240, 0, 32'h6, 32'h4C0, 32'h8C0, 16);
    fill_src(32'h4C0, 16, 32'h7777_0000);
    exp_copy(32'h4C0, 32'h8C0, 16); exp_done(32'h240);
    wr_cmd(32'h240); wr_sema(8'd1); settle();
    exp_irq += 1;
    cmp_mem("R7 copy before halt");
    check("R7 code next zero", chan_status, 32'h0001_0000);
    check("R9 forced irq", 32'(irq_cnt), 32'(exp_irq));
    check("R9 halted", 32'(running), 0);

    // R8: byte count not a multiple of 16
    clr_ok();
    put_desc(32'h260, 0, 32'h3, 32'h4E0, 32'h8E0, 20);
    wr_cmd(32'h260);
    check("R11 status cleared", chan_status, 0);
    wr_sema(8'd1); settle();
    exp_irq += 1;
    check("R8 setup flag", chan_status, 32'h0000_0004);
    cmp_mem("R8 nothing written");
    check("R8 irq", 32'(irq_cnt), 32'(exp_irq));
    check("R3 no decrement on error", 32'(sema_count), 1);

    // R9: source read error, irq bit clear
    put_desc(32'h280, 0, 32'h2, 32'h8000_0000, 32'h900, 16);
    wr_cmd(32'h280); wr_sema(8'd0); settle();
    exp_irq += 1;
    check("R9 source flag", chan_status, 32'h0000_0010);
    check("R9 source irq", 32'(irq_cnt), 32'(exp_irq));

    // R9: destination write error
    put_desc(32'h2A0, 0, 32'h2, 32'h500, 32'h8000_0040, 16);
    fill_src(32'h500, 16, 32'h8888_0000);
    wr_cmd(32'h2A0); wr_sema(8'd0); settle();
    exp_irq += 1;
    check("R9 destination flag", chan_status, 32'h0000_0020);
    check("R9 destination irq", 32'(irq_cnt), 32'(exp_irq));

    // R9: descriptor fetch error
    wr_cmd(32'h8000_0100); wr_sema(8'd0); settle();
    exp_irq += 1;
    check("R9 fetch flag", chan_status, 32'h0000_0008);
    check("R9 fetch halted", 32'(running), 0);

    // R10: cipher with both key sources
    put_desc(32'h2C0, 0, 32'hC22, 32'h520, 32'h920, 16);
    fill_src(32'h520, 16, 32'h9999_0000);
    wr_cmd(32'h2C0); wr_sema(8'd0); settle();
    exp_irq += 1;
    check("R10 invalid mode code", chan_status, 32'h0005_0000);
    cmp_mem("R10 nothing written");

    // R1: cipher path with one key source copies unchanged
    clr_ok();
    put_desc(32'h2E0, 0, 32'hB23, 32'h540, 32'h940, 16);
    fill_src(32'h540, 16, 32'hC3C3_0000);
    exp_copy(32'h540, 32'h940, 16); exp_done(32'h2E0);
    wr_cmd(32'h2E0); wr_sema(8'd0); settle();
    exp_irq += 1;
    cmp_mem("R1 cipher hook pass-through");
    check("R1 clean status", chan_status, 0);
    check("R3 count after cipher run", 32'(sema_count), 0);
    check("R5 total irq pulses", 32'(irq_cnt), 32'(exp_irq));

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule